// File: doc/BRIEF.md
# Redundant Reference Clock Switchover Controller

This block chooses which of two reference clocks feeds a downstream PLL. It drives the registered select of a 2:1 clock multiplexer. Select value 0 picks the primary input `ref_a_clk` and select value 1 picks the secondary input `ref_b_clk`. The block watches both inputs from its own system clock. When an input stops toggling for a programmable number of system cycles, that input's dead flag rises.

A small state machine uses the dead flags. When automatic failover is enabled, it moves the selection away from a dead active input, but only if the other input is alive. A switch request pin, driven by the user or by the system, flips the selection on every rising edge whether automatic mode is on or off. The manual pin is the path to use when the two references differ in frequency by more than about 20%, because the activity sensing is only trustworthy for inputs of near-equal frequency.

After every switchover the state machine waits a fixed hold-off before it makes another automatic decision. A sticky loss flag records that either input was seen dead. The design has no data stream, so every pin is a plain level control or status signal.

Top module: `refclk_switchover`

## Requirements
- R1: While `rst_n` is low and after it is released, `sel_b` is 0 (primary), `bad_a`, `bad_b` and `clk_loss` are 0, and the controller starts in its monitoring state.
- R2: A dead flag rises when its input has shown no edge for `WINDOW` system cycles (16 by default). It falls again within a few cycles after edges return.
- R3: With `auto_en` = 1, outside hold-off, if the selected input is dead and the other is alive, `sel_b` toggles on the next system clock edge. This works in both directions.
- R4: With `auto_en` = 0, a dead active input never changes `sel_b`.
- R5: Each rising edge of `switch_req` toggles `sel_b` exactly once, about three system cycles later. How long the pin stays high does not matter. This happens whatever the values of `auto_en`, the dead flags and the hold-off.
- R6: After any toggle of `sel_b`, no automatic switch occurs for `HOLDOFF` system cycles (16 by default).
- R7: While both dead flags are high, `sel_b` holds its value unless a manual request arrives.
- R8: `clk_loss` is set in the cycle after either dead flag is high. It stays set until `loss_clr` is high while both flags are low. If `loss_clr` and a dead flag coincide, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Free-running system clock for monitoring and control |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a_clk | input | 1 | Primary reference clock candidate |
| ref_b_clk | input | 1 | Secondary reference clock candidate |
| auto_en | input | 1 | 1 enables automatic failover |
| switch_req | input | 1 | Manual switch request; each rising edge flips the selection |
| loss_clr | input | 1 | Clears the sticky loss flag |
| sel_b | output | 1 | Mux select: 0 = primary, 1 = secondary (active-input indicator) |
| bad_a | output | 1 | Primary input judged dead |
| bad_b | output | 1 | Secondary input judged dead |
| clk_loss | output | 1 | Sticky: a dead input was observed |

## Verification
Two cases can fall in the same cycle. The first is a clear of the loss flag while a dead flag is still high. The bench stops the secondary clock, waits for its flag, and then pulses `loss_clr`. It judges that `clk_loss` stays set, because set has priority. The second is a manual toggle during a pending automatic condition: a request moves the selection back onto a dead input. The bench checks that the selection holds for the hold-off and then fails over automatically. Random manual requests with random `auto_en` and hold lengths are checked against a bench model of the selection.

// File: rtl/refclk_switch_pkg.sv
package refclk_switch_pkg;
  typedef enum logic [0:0] {
    ST_WATCH = 1'b0,
    ST_HOLD  = 1'b1
  } sw_state_e;
endpackage

// File: rtl/refclk_activity_mon.sv
module refclk_activity_mon #(
  parameter int WINDOW = 16,
  parameter int SYNC   = 2
) (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic dead
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW - 1);

  // toggle flop in the watched clock's own domain
  logic tgl;
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  // synchronizer plus one delay stage for edge detection
  logic [SYNC:0] chain;
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC-1:0], tgl};
  end

  logic seen_edge;
  assign seen_edge = chain[SYNC] ^ chain[SYNC-1];

  logic [CW-1:0] quiet_cnt;
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      dead      <= 1'b0;
    end else if (seen_edge) begin
      quiet_cnt <= '0;
      dead      <= 1'b0;
    end else if (quiet_cnt == LIMIT) begin
      dead      <= 1'b1;
    end else begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/refclk_req_edge.sv
module refclk_req_edge #(
  parameter int SYNC = 2
) (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic req_in,
  output logic rise_pulse
);
  logic [SYNC:0] chain;
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC-1:0], req_in};
  end
  assign rise_pulse = chain[SYNC-1] & ~chain[SYNC];
endmodule

// File: rtl/refclk_switch_fsm.sv
module refclk_switch_fsm
  import refclk_switch_pkg::*;
#(
  parameter int HOLDOFF = 16
) (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic sw_pulse,
  input  logic bad_a,
  input  logic bad_b,
  output logic sel_b,
  output logic in_holdoff
);
  localparam int HW = $clog2(HOLDOFF + 1);
  localparam logic [HW-1:0] HLAST = HW'(HOLDOFF - 1);

  sw_state_e     state;
  logic [HW-1:0] hold_cnt;
  logic          act_bad, alt_bad, auto_go, do_flip;

  assign act_bad = sel_b ? bad_b : bad_a;
  assign alt_bad = sel_b ? bad_a : bad_b;
  assign auto_go = auto_en && (state == ST_WATCH) && act_bad && !alt_bad;
  assign do_flip = sw_pulse || auto_go;
  assign in_holdoff = (state == ST_HOLD);

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_WATCH;
      sel_b    <= 1'b0;
      hold_cnt <= '0;
    end else if (do_flip) begin
      sel_b    <= ~sel_b;
      state    <= ST_HOLD;
      hold_cnt <= '0;
    end else if (state == ST_HOLD) begin
      if (hold_cnt == HLAST) state <= ST_WATCH;
      else                   hold_cnt <= hold_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/refclk_switchover.sv
module refclk_switchover #(
  parameter int WINDOW  = 16,
  parameter int HOLDOFF = 16,
  parameter int SYNC    = 2
) (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic ref_a_clk,
  input  logic ref_b_clk,
  input  logic auto_en,
  input  logic switch_req,
  input  logic loss_clr,
  output logic sel_b,
  output logic bad_a,
  output logic bad_b,
  output logic clk_loss
);
  localparam int NREF = 2;

  logic [NREF-1:0] ref_clks;
  logic [NREF-1:0] dead_vec;
  logic            sw_pulse;
  logic            in_holdoff;

  assign ref_clks = {ref_b_clk, ref_a_clk};

  for (genvar i = 0; i < NREF; i++) begin : g_mon
    refclk_activity_mon #(.WINDOW(WINDOW), .SYNC(SYNC)) u_mon (
      .sys_clk (sys_clk),
      .rst_n   (rst_n),
      .mon_clk (ref_clks[i]),
      .dead    (dead_vec[i])
    );
  end

  assign bad_a = dead_vec[0];
  assign bad_b = dead_vec[1];

  refclk_req_edge #(.SYNC(SYNC)) u_req (
    .sys_clk    (sys_clk),
    .rst_n      (rst_n),
    .req_in     (switch_req),
    .rise_pulse (sw_pulse)
  );

  refclk_switch_fsm #(.HOLDOFF(HOLDOFF)) u_fsm (
    .sys_clk    (sys_clk),
    .rst_n      (rst_n),
    .auto_en    (auto_en),
    .sw_pulse   (sw_pulse),
    .bad_a      (bad_a),
    .bad_b      (bad_b),
    .sel_b      (sel_b),
    .in_holdoff (in_holdoff)
  );

  // sticky loss record; setting outranks clearing
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n)                clk_loss <= 1'b0;
    else if (|dead_vec)        clk_loss <= 1'b1;
    else if (loss_clr)         clk_loss <= 1'b0;
  end
endmodule

// File: rtl/refclk_switch_chk.sv
module refclk_switch_chk (
  input logic sys_clk,
  input logic rst_n,
  input logic sel_b,
  input logic bad_a,
  input logic bad_b,
  input logic clk_loss,
  input logic loss_clr,
  input logic sw_pulse,
  input logic in_holdoff
);
  // R8
  loss_sticky_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    clk_loss && !loss_clr |=> clk_loss);

  // R8
  loss_set_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (bad_a || bad_b) |=> clk_loss);

  // R7
  both_dead_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (bad_a && bad_b && !sw_pulse) |=> $stable(sel_b));

  // R6
  holdoff_quiet_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (in_holdoff && !sw_pulse) |=> $stable(sel_b));

  // R5
  manual_flip_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    sw_pulse |=> (sel_b != $past(sel_b)));

  // R5
  single_pulse_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    sw_pulse |=> !sw_pulse);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (!clk_loss && !sel_b);
    end
  end
endmodule

bind refclk_switchover refclk_switch_chk u_chk (
  .sys_clk    (sys_clk),
  .rst_n      (rst_n),
  .sel_b      (sel_b),
  .bad_a      (bad_a),
  .bad_b      (bad_b),
  .clk_loss   (clk_loss),
  .loss_clr   (loss_clr),
  .sw_pulse   (sw_pulse),
  .in_holdoff (in_holdoff)
);

// File: tb/refclk_switchover_test.sv
`timescale 1ns/1ps
module refclk_switchover_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_a = 1'b0, ref_b = 1'b0;
  logic a_run = 1'b1, b_run = 1'b1;
  logic auto_en = 1'b0, switch_req = 1'b0, loss_clr = 1'b0;
  logic sel_b, bad_a, bad_b, clk_loss;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;
  logic exp_sel;

  always #2.5 clk = ~clk;
  initial forever begin #15; if (a_run) ref_a = ~ref_a; end
  initial forever begin #20; if (b_run) ref_b = ~ref_b; end

  refclk_switchover uut (
    .sys_clk(clk), .rst_n(rst_n), .ref_a_clk(ref_a), .ref_b_clk(ref_b),
    .auto_en(auto_en), .switch_req(switch_req), .loss_clr(loss_clr),
    .sel_b(sel_b), .bad_a(bad_a), .bad_b(bad_b), .clk_loss(clk_loss)
  );

  function automatic logic model_flip(input logic cur, input bit manual);
    return manual ? ~cur : cur;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic manual(input int hold);
    switch_req = 1'b1;
    cyc(hold);
    switch_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    cyc(3);
    // R1 during reset
    chk("R1 sel", sel_b, 1'b0);
    chk("R1 loss", clk_loss, 1'b0);
    rst_n = 1'b1;
    cyc(10);
    chk("R1 sel after release", sel_b, 1'b0);
    chk("R1 bad_a", bad_a, 1'b0);
    chk("R1 bad_b", bad_b, 1'b0);
    chk("R1 loss after release", clk_loss, 1'b0);

    // R5 random manual requests, both clocks alive
    exp_sel = 1'b0;
    for (int i = 0; i < 12; i++) begin
      auto_en = 1'($urandom % 2);
      manual(1 + int'($urandom % 10));
      cyc(5);
      exp_sel = model_flip(exp_sel, 1'b1);
      chk("R5 manual toggle", sel_b, exp_sel);
    end
    if (sel_b) begin manual(2); cyc(5); end
    cyc(20);
    chk("R5 back on primary", sel_b, 1'b0);

    // R4 automatic disabled, primary dies
    auto_en = 1'b0;
    a_run = 1'b0;
    cyc(40);
    chk("R2 bad_a rises", bad_a, 1'b1);
    chk("R4 no auto switch", sel_b, 1'b0);
    chk("R8 loss set", clk_loss, 1'b1);

    // R3 enable automatic failover
    auto_en = 1'b1;
    cyc(5);
    chk("R3 failover to secondary", sel_b, 1'b1);

    // R6 manual back onto dead primary, hold-off then fail over again
    manual(1);
    cyc(7);
    chk("R6 held on primary", sel_b, 1'b0);
    cyc(25);
    chk("R6 auto after hold-off", sel_b, 1'b1);

    // R2 recovery and R8 clear
    a_run = 1'b1;
    cyc(40);
    chk("R2 bad_a clears", bad_a, 1'b0);
    loss_clr = 1'b1; cyc(1); loss_clr = 1'b0;
    cyc(2);
    chk("R8 loss cleared", clk_loss, 1'b0);

    // R3 secondary dies while active
    b_run = 1'b0;
    cyc(40);
    chk("R2 bad_b rises", bad_b, 1'b1);
    chk("R3 failover to primary", sel_b, 1'b0);
    loss_clr = 1'b1; cyc(1); loss_clr = 1'b0;
    cyc(2);
    chk("R8 set wins over clear", clk_loss, 1'b1);

    // R7 both dead
    a_run = 1'b0;
    cyc(60);
    chk("R7 bad_a", bad_a, 1'b1);
    chk("R7 selection held", sel_b, 1'b0);
    chk("R7 loss held", clk_loss, 1'b1);

    // R3 recovery of secondary
    b_run = 1'b1;
    cyc(40);
    chk("R2 bad_b clears", bad_b, 1'b0);
    chk("R3 switch to recovered input", sel_b, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule